// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of a linear grating scale, plus its index pulse, into a signed 16-bit position count that a processor reads over a small parallel bus. The A, B and Z lines are brought into the system clock domain through two-flop synchronizers. A phase-tracking state machine compares the current synchronized AB pair with the previous one. Each legal edge of either line moves the count by one, so the count changes four times per signal period. The direction of each step follows from which line leads.

A transition in which both lines change in the same sample cannot be decoded. It produces no count and sets a sticky error flag. A rising edge on Z either zeroes the count or only records that the index was seen, depending on a control bit. The processor reads the position through a latch. A read strobe copies all 16 bits in one clock, so the value read never mixes bits from two different counts. Writes to the control address set the index mode, clear the count and clear the flags.

The phase state machine has four states named after the last sampled AB value (A is bit 1, B is bit 0): PH00, PH01, PH11 and PH10. From any state, one of four transitions is taken:
- UP moves to the next state in the order PH00, PH01, PH11, PH10, PH00.
- DOWN moves to the previous state in that order.
- HOLD is taken when the input equals the state.
- BAD is taken when the input is the opposite corner. BAD jumps to that state and flags an error.

Top module: `qdec_position`

## Requirements
- R1: A single edge on A or B is reflected in the internal count by the third rising clock edge after the input changes (two synchronizer stages and one count register).
- R2: With AB read as a 2-bit code {A,B}, the transitions 00→01, 01→11, 11→10 and 10→00 each add one to the count.
- R3: The transitions 00→10, 10→11, 11→01 and 01→00 each subtract one from the count.
- R4: A transition in which A and B both change (00↔11 or 01↔10) leaves the count unchanged and sets the error flag, status bit 0. The flag stays set until cleared by a control write or reset.
- R5: The count wraps modulo 2^16: one step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R6: When the index-enable bit (control bit 0, readable as status bit 2) is 1, a rising edge of Z clears the count to 0. A clear in the same cycle as a step takes priority over the step.
- R7: When index-enable is 0, a rising edge of Z leaves the count unchanged and sets the index-seen flag, status bit 1. With index-enable set, the flag is also set.
- R8: A read strobe (bus_cs and bus_rd high) at address 0 copies the whole count into the position latch at that clock edge. bus_rdata at address 0 shows the latch, which does not change until the next such read.
- R9: A write (bus_cs and bus_wr high) at address 1 loads index-enable from data bit 0. Data bit 1 = 1 clears the count. Data bit 2 = 1 clears the error flag. Data bit 3 = 1 clears the index-seen flag. A flag event in the same cycle as its clear keeps the flag set.
- R10: Synchronous reset clears the count, latch, index-enable and both flags. Address 1 reads as zero-extended {index_en, index_seen, error}, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Quadrature line A, asynchronous |
| enc_b | input | 1 | Quadrature line B, asynchronous |
| enc_z | input | 1 | Index pulse, asynchronous |
| bus_cs | input | 1 | Bus chip select |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address: 0 position, 1 control/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data: position latch or status |

## Verification
The assertions assume that the processor never asserts read and write together. They also assume that at most one encoder line changes per synchronized sample, except where a both-lines change is deliberately applied to exercise the error path. The one-step-per-cycle property further relies on the count being cleared only by reset, a control write or an index edge. The stimulus keeps within these assumptions in three ways:
- It holds every encoder level for four clocks, which is longer than the synchronizer and count latency.
- It drives bus strobes one at a time at the falling clock edge.
- It applies the random both-lines flips only as whole two-state jumps, against a bench model that expects no count and a set error flag.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    // Last sampled {A,B} phase; encoding equals the input code
    typedef enum logic [1:0] {
        PH00 = 2'b00,
        PH01 = 2'b01,
        PH11 = 2'b11,
        PH10 = 2'b10
    } qphase_e;

    // Decoded step for one clock
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10,
        STEP_BAD  = 2'b11
    } step_e;

    // Control word bit positions
    localparam int CTL_IDX_EN   = 0;
    localparam int CTL_CLR_POS  = 1;
    localparam int CTL_CLR_ERR  = 2;
    localparam int CTL_CLR_SEEN = 3;

    // Register addresses
    localparam int ADDR_POS  = 0;
    localparam int ADDR_CTRL = 1;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_phase_fsm.sv
module qdec_phase_fsm
    import qdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  ab,
    output step_e       step
);
    qphase_e state_q;
    qphase_e up_ph;
    qphase_e dn_ph;

    // State register: always follows the sampled phase
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH00;
        else     state_q <= qphase_e'(ab);
    end

    // Output: classify the transition out of the current state
    always_comb begin
        unique case (state_q)
            PH00: begin up_ph = PH01; dn_ph = PH10; end
            PH01: begin up_ph = PH11; dn_ph = PH00; end
            PH11: begin up_ph = PH10; dn_ph = PH01; end
            PH10: begin up_ph = PH00; dn_ph = PH11; end
        endcase
        if (ab == state_q)      step = STEP_HOLD;
        else if (ab == up_ph)   step = STEP_UP;
        else if (ab == dn_ph)   step = STEP_DOWN;
        else                    step = STEP_BAD;
    end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  step_e            step,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)              pos <= '0;
        else if (step == STEP_UP)    pos <= pos + ONE;
        else if (step == STEP_DOWN)  pos <= pos - ONE;
    end
endmodule

// File: rtl/qdec_position.sv
module qdec_position
    import qdec_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int ADDR_W    = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_z,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [POS_W-1:0]  bus_wdata,
    output logic [POS_W-1:0]  bus_rdata
);
    localparam int STAT_W = 3;

    logic [2:0]        raw_in;
    logic [2:0]        sync_in;
    logic              z_s, z_prev_q, z_rise;
    step_e             step;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  latch_q;
    logic              idx_en_q, err_q, seen_q;
    logic              rd_pos, wr_ctrl, clr_pos;
    logic [STAT_W-1:0] status;
    logic              wdata_unused;

    assign raw_in = {enc_z, enc_a, enc_b};

    qdec_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_in)
    );

    assign z_s = sync_in[2];

    qdec_phase_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .ab   (sync_in[1:0]),
        .step (step)
    );

    always_ff @(posedge clk) begin
        if (rst) z_prev_q <= 1'b0;
        else     z_prev_q <= z_s;
    end
    assign z_rise = z_s & ~z_prev_q;

    assign rd_pos  = bus_cs && bus_rd && (bus_addr == ADDR_W'(ADDR_POS));
    assign wr_ctrl = bus_cs && bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign clr_pos = (wr_ctrl && bus_wdata[CTL_CLR_POS]) || (z_rise && idx_en_q);

    qdec_counter #(.POS_W(POS_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_pos),
        .step (step),
        .pos  (pos_q)
    );

    // Control and status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_en_q <= 1'b0;
            err_q    <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            if (wr_ctrl) idx_en_q <= bus_wdata[CTL_IDX_EN];
            err_q  <= (err_q  & ~(wr_ctrl && bus_wdata[CTL_CLR_ERR]))  | (step == STEP_BAD);
            seen_q <= (seen_q & ~(wr_ctrl && bus_wdata[CTL_CLR_SEEN])) | z_rise;
        end
    end

    // Read latch: whole word in one edge
    always_ff @(posedge clk) begin
        if (rst)         latch_q <= '0;
        else if (rd_pos) latch_q <= pos_q;
    end

    assign status       = {idx_en_q, seen_q, err_q};
    assign wdata_unused = ^bus_wdata[POS_W-1:CTL_CLR_SEEN+1];

    always_comb begin
        if (bus_addr == ADDR_W'(ADDR_POS))       bus_rdata = latch_q;
        else if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata = POS_W'(status);
        else                                     bus_rdata = '0;
    end
endmodule

// File: rtl/qdec_position_chk.sv
module qdec_position_chk
    import qdec_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [POS_W-1:0]  bus_wdata,
    input step_e             step,
    input logic [POS_W-1:0]  pos_q,
    input logic [POS_W-1:0]  latch_q,
    input logic              err_q
);
    logic rd_pos, wr_ctrl;
    assign rd_pos  = bus_cs && bus_rd && (bus_addr == ADDR_W'(ADDR_POS));
    assign wr_ctrl = bus_cs && bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));

    // R2 R3 R5: count moves by at most one per clock unless cleared
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1)) ||
        (pos_q == $past(pos_q) - POS_W'(1)) || (pos_q == '0));

    // R4: an undecodable transition leaves the count and raises the flag
    assert_bad_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_BAD) |=> err_q);

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(wr_ctrl && bus_wdata[CTL_CLR_ERR])) |=> err_q);

    // R8: latch captures on a read and holds otherwise
    assert_latch_capture_R8: assert property (@(posedge clk) disable iff (rst)
        rd_pos |=> (latch_q == $past(pos_q)));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_pos |=> $stable(latch_q));

    // R9: control write with clear bit zeroes the count
    assert_wr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[CTL_CLR_POS]) |=> (pos_q == '0));
endmodule

bind qdec_position qdec_position_chk #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cs    (bus_cs),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .step      (step),
    .pos_q     (pos_q),
    .latch_q   (latch_q),
    .err_q     (err_q)
);

// File: tb/qdec_position_test.sv
module qdec_position_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
    logic        bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model
    int          phase_idx = 0;      // index into gray order 00,01,11,10
    logic [15:0] mpos = 16'd0;
    bit          merr = 1'b0, mseen = 1'b0, midx = 1'b0;

    always #10 clk = ~clk;           // 50 MHz

    qdec_position uut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [1:0] gray_code(int idx);
        case (idx & 3)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [15:0] status_word(bit e, bit s, bit i);
        return {13'd0, i, s, e};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_ab();
        @(negedge clk);
        {enc_a, enc_b} = gray_code(phase_idx);
        repeat (4) @(negedge clk);
    endtask

    task automatic step_up();
        phase_idx = (phase_idx + 1) & 3; mpos = mpos + 16'd1; drive_ab();
    endtask

    task automatic step_down();
        phase_idx = (phase_idx + 3) & 3; mpos = mpos - 16'd1; drive_ab();
    endtask

    task automatic step_flip();
        phase_idx = (phase_idx + 2) & 3; merr = 1'b1; drive_ab();
    endtask

    task automatic pulse_z();
        @(negedge clk); enc_z = 1'b1;
        repeat (4) @(negedge clk); enc_z = 1'b0;
        repeat (4) @(negedge clk);
        mseen = 1'b1;
        if (midx) mpos = 16'd0;
    endtask

    task automatic read_pos(output logic [15:0] val);
        @(negedge clk); bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = 2'd0;
        @(negedge clk); bus_cs = 1'b0; bus_rd = 1'b0;
        val = bus_rdata;
    endtask

    task automatic read_stat(output logic [15:0] val);
        @(negedge clk); bus_addr = 2'd1; #1 val = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic write_ctrl(logic [15:0] d);
        @(negedge clk); bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = d;
        @(negedge clk); bus_cs = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 16'd0;
        midx = d[0];
        if (d[1]) mpos = 16'd0;
        if (d[2]) merr = 1'b0;
        if (d[3]) mseen = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        read_stat(v);   check("R10 status after reset", v, 16'h0000);
        read_pos(v);    check("R10 count after reset", v, 16'h0000);

        // R1 latency: count changed by the third edge after input change
        @(negedge clk); enc_b = 1'b1; phase_idx = 1; mpos = 16'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_pos(v);    check("R1 latency single edge", v, 16'd1);

        // R2 full forward cycle
        step_up(); step_up(); step_up();
        read_pos(v);    check("R2 forward four edges", v, 16'd4);

        // R3 reverse
        step_down(); step_down();
        read_pos(v);    check("R3 reverse two edges", v, 16'd2);

        // R5 wrap below zero and back
        step_down(); step_down(); step_down();
        read_pos(v);    check("R5 wrap to FFFF", v, 16'hFFFF);
        step_up();
        read_pos(v);    check("R5 wrap to 0000", v, 16'h0000);

        // R4 double flip
        step_flip();
        read_pos(v);    check("R4 flip no count", v, mpos);
        read_stat(v);   check("R4 error flag set", v, status_word(1, 0, 0));
        step_up();
        read_stat(v);   check("R4 error flag sticky", v, status_word(1, 0, 0));

        // R9 clear error only
        write_ctrl(16'h0004);
        read_stat(v);   check("R9 clear error", v, status_word(0, 0, 0));

        // R7 index disabled
        step_up(); step_up();
        pulse_z();
        read_pos(v);    check("R7 index disabled keeps count", v, mpos);
        read_stat(v);   check("R7 index seen flag", v, status_word(0, 1, 0));

        // R9 clear seen, enable index
        write_ctrl(16'h0009);
        read_stat(v);   check("R9 clear seen and set index enable", v, status_word(0, 0, 1));

        // R6 index clears count
        step_up();
        pulse_z();
        read_pos(v);    check("R6 index clears count", v, 16'd0);
        read_stat(v);   check("R6 seen set with enable", v, status_word(0, 1, 1));

        // R8 latch holds
        step_up(); step_up(); step_up();
        read_pos(held); check("R8 latch capture", held, mpos);
        step_up(); step_up();
        @(negedge clk); v = bus_rdata;
        check("R8 latch holds without read", v, held);
        read_pos(v);    check("R8 latch recapture", v, mpos);

        // R9 clear count by write
        write_ctrl(16'h0003);
        read_pos(v);    check("R9 write clears count", v, 16'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45)      step_up();
            else if (r < 88) step_down();
            else if (r < 92) step_flip();
            else if (r < 95) pulse_z();
            else if (r < 97) write_ctrl({12'd0, 1'b1, 1'b1, 1'b0, 1'($urandom_range(0, 1))});
            if ((i % 8) == 7) begin
                read_pos(v);  check("R2 R3 random count", v, mpos);
                read_stat(v); check("R4 R7 random status", v, status_word(merr, mseen, midx));
            end
        end

        // R10 reset mid-run
        step_up(); step_up();
        read_pos(v);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        mpos = 16'd0; merr = 1'b0; mseen = 1'b0; midx = 1'b0;
        @(negedge clk); v = bus_rdata;
        check("R10 latch cleared by reset", v, 16'd0);
        read_stat(v);   check("R10 flags cleared by reset", v, 16'h0000);
        read_pos(v);    check("R10 count cleared by reset", v, 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule